// File: doc/BRIEF.md
# Loop Current Sense Combiner

This block turns four sensed branch currents of a telephone line driver into one signed loop-current sample. It also raises a common-mode-high flag when a common-mode measurement is above a programmed threshold. That flag and the 3-bit linefeed state together decide two things: whether one branch current is replaced by zero, and whether the combined value is halved. The result feeds a downstream loop-closure filter.

Samples arrive on a valid/ready stream. A sample is accepted on a cycle where `in_valid` and `in_ready` are both high. In that cycle the block captures all the inputs, including the state code and the threshold. The result appears on the output stream in the next cycle. The block holds one sample at a time.

Back-pressure works as follows. While `out_valid` is high and `out_ready` is low, the output holds its value and `in_ready` stays low, so no input is taken. When `out_ready` is high, a new sample can be accepted in the same cycle that the held result is consumed.

Top module: `lcs_loop_combiner`

## Requirements
- R1: `out_cm_high` is 1 when the captured common-mode value is strictly greater than the captured threshold (unsigned compare). It is 0 when the two are equal or when the value is lower.
- R2: With the flag set and state code 1 or 3, branch current Q1 is replaced by zero before combining.
- R3: With the flag set and state code 5 or 7, branch current Q2 is replaced by zero before combining.
- R4: In state codes 3 and 7, `out_loop` is Q1 − Q6 + Q5 − Q2, with no halving.
- R5: In state codes 0, 1, 2, 4, 5 and 6, `out_loop` is (Q1 − Q6 + Q5 − Q2) arithmetically shifted right by one. This rounds toward minus infinity, so −3 gives −2.
- R6: A current that is not forced to zero always contributes at full weight. When the flag is clear, no current is zeroed in any state. When the flag is set in states 0, 2, 4 or 6, no current is zeroed either.
- R7: The result saturates to the signed 16-bit range [−32768, 32767].
- R8: A sample accepted on clock edge N gives `out_valid` = 1 with its result and flag after edge N. `in_ready` is high whenever the output is empty or `out_ready` is high.
- R9: While `out_valid` is high and `out_ready` is low, `out_loop` and `out_cm_high` stay stable, `out_valid` stays high, and `in_ready` is low.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_loop` and `out_cm_high` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_q1 | input | 16 | Signed branch current Q1 |
| in_q2 | input | 16 | Signed branch current Q2 |
| in_q5 | input | 16 | Signed branch current Q5 |
| in_q6 | input | 16 | Signed branch current Q6 |
| in_lf_state | input | 3 | Linefeed state code |
| in_cm | input | 16 | Unsigned common-mode measurement |
| in_cm_thr | input | 16 | Unsigned common-mode threshold |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_loop | output | 16 | Signed loop-current result |
| out_cm_high | output | 1 | Common-mode-high flag for this sample |

## Verification
The bench runs each state code with the flag set and with it clear. A design that zeroes the wrong branch, or zeroes a branch in a state where none should be zeroed, gives a result that differs from the model by exactly that branch's weight.

The common-mode value is also set equal to the threshold. A design that uses ≥ instead of > raises the flag there and wrongly drops a branch.

Odd negative sums and out-of-range sums catch two other faults. A design that rounds toward zero is off by one. A design that wraps instead of saturating flips sign.

A stalled-output scenario offers a new sample while `out_ready` is low. A design that ignores back-pressure overwrites the held result.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  // Linefeed state codes the combiner decodes
  localparam logic [2:0] LF_FWD_ACTIVE = 3'd1;
  localparam logic [2:0] LF_TIP_OPEN   = 3'd3;
  localparam logic [2:0] LF_REV_ACTIVE = 3'd5;
  localparam logic [2:0] LF_RING_OPEN  = 3'd7;

  // Branch positions in the packed term vector
  localparam int IDX_Q1 = 0;
  localparam int IDX_Q2 = 1;
  localparam int IDX_Q5 = 2;
  localparam int IDX_Q6 = 3;
  localparam int N_BR   = 4;

  function automatic logic q1_killable(input logic [2:0] lf);
    return (lf == LF_FWD_ACTIVE) || (lf == LF_TIP_OPEN);
  endfunction

  function automatic logic q2_killable(input logic [2:0] lf);
    return (lf == LF_REV_ACTIVE) || (lf == LF_RING_OPEN);
  endfunction

  // Open-leg states use the full sum; all other states halve it
  function automatic logic full_sum_state(input logic [2:0] lf);
    return (lf == LF_TIP_OPEN) || (lf == LF_RING_OPEN);
  endfunction

endpackage

// File: rtl/lcs_cm_detect.sv
module lcs_cm_detect #(
  parameter int CM_W = 16
) (
  input  logic [CM_W-1:0] cm_i,
  input  logic [CM_W-1:0] thr_i,
  output logic            high_o
);
  assign high_o = (cm_i > thr_i);
endmodule

// File: rtl/lcs_term_sum.sv
module lcs_term_sum
  import lcs_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              SUM_W    = DATA_W + 2,
  parameter logic [N_BR-1:0] NEG_MASK = 4'b1010
) (
  input  logic [N_BR-1:0][DATA_W-1:0] br_i,
  input  logic [N_BR-1:0]             kill_i,
  output logic signed [SUM_W-1:0]     sum_o
);
  localparam int EXT_W = SUM_W - DATA_W;

  logic signed [SUM_W-1:0] term [N_BR];

  for (genvar g = 0; g < N_BR; g++) begin : g_term
    logic signed [SUM_W-1:0] ext;
    assign ext = kill_i[g] ? '0 : {{EXT_W{br_i[g][DATA_W-1]}}, br_i[g]};
    if (NEG_MASK[g]) begin : g_neg
      assign term[g] = -ext;
    end else begin : g_pos
      assign term[g] = ext;
    end
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N_BR; i++) sum_o = sum_o + term[i];
  end

  // Zeroed branches must never both be active at once
  always_comb begin
    assert (!(kill_i[IDX_Q1] && kill_i[IDX_Q2]))
      else $error("AST_SINGLE_KILL: both Q1 and Q2 forced"); // R2
  end
endmodule

// File: rtl/lcs_scale_sat.sv
module lcs_scale_sat #(
  parameter int DATA_W = 16,
  parameter int SUM_W  = DATA_W + 2
) (
  input  logic signed [SUM_W-1:0]  sum_i,
  input  logic                     halve_i,
  output logic signed [DATA_W-1:0] res_o
);
  localparam int PAD_W = SUM_W - DATA_W + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = {{PAD_W{1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_LO = {{PAD_W{1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [SUM_W-1:0] scaled;

  always_comb begin
    scaled = halve_i ? (sum_i >>> 1) : sum_i;
    if (scaled > SAT_HI)      res_o = SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) res_o = SAT_LO[DATA_W-1:0];
    else                      res_o = scaled[DATA_W-1:0];
  end
endmodule

// File: rtl/lcs_loop_combiner.sv
module lcs_loop_combiner
  import lcs_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              CM_W     = 16,
  parameter logic [N_BR-1:0] NEG_MASK = 4'b1010
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_q1,
  input  logic signed [DATA_W-1:0] in_q2,
  input  logic signed [DATA_W-1:0] in_q5,
  input  logic signed [DATA_W-1:0] in_q6,
  input  logic [2:0]               in_lf_state,
  input  logic [CM_W-1:0]          in_cm,
  input  logic [CM_W-1:0]          in_cm_thr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_loop,
  output logic                     out_cm_high
);
  localparam int SUM_W = DATA_W + 2;

  logic                        hold_v;
  logic [N_BR-1:0][DATA_W-1:0] br_q;
  logic [2:0]                  lf_q;
  logic [CM_W-1:0]             cm_q;
  logic [CM_W-1:0]             thr_q;
  logic                        take;
  logic                        cm_hi;
  logic [N_BR-1:0]             kill;
  logic signed [SUM_W-1:0]     sum;

  assign in_ready = !hold_v || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      br_q   <= '0;
      lf_q   <= '0;
      cm_q   <= '0;
      thr_q  <= '0;
    end else begin
      if (take) begin
        br_q[IDX_Q1] <= in_q1;
        br_q[IDX_Q2] <= in_q2;
        br_q[IDX_Q5] <= in_q5;
        br_q[IDX_Q6] <= in_q6;
        lf_q         <= in_lf_state;
        cm_q         <= in_cm;
        thr_q        <= in_cm_thr;
        hold_v       <= 1'b1;
      end else if (out_ready) begin
        hold_v <= 1'b0;
      end
    end
  end

  lcs_cm_detect #(.CM_W(CM_W)) i_cm (
    .cm_i   (cm_q),
    .thr_i  (thr_q),
    .high_o (cm_hi)
  );

  always_comb begin
    kill         = '0;
    kill[IDX_Q1] = cm_hi && q1_killable(lf_q);
    kill[IDX_Q2] = cm_hi && q2_killable(lf_q);
  end

  lcs_term_sum #(.DATA_W(DATA_W), .SUM_W(SUM_W), .NEG_MASK(NEG_MASK)) i_sum (
    .br_i   (br_q),
    .kill_i (kill),
    .sum_o  (sum)
  );

  lcs_scale_sat #(.DATA_W(DATA_W), .SUM_W(SUM_W)) i_sat (
    .sum_i   (sum),
    .halve_i (!full_sum_state(lf_q)),
    .res_o   (out_loop)
  );

  assign out_valid   = hold_v;
  assign out_cm_high = cm_hi;

  // Assertions
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_loop == '0 && !out_cm_high)); // R10

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_loop) && $stable(out_cm_high))); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_Q1_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cm_high && lf_q == LF_FWD_ACTIVE &&
     br_q[IDX_Q2] == '0 && br_q[IDX_Q5] == '0 && br_q[IDX_Q6] == '0) |-> out_loop == '0); // R2

  AST_Q2_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cm_high && lf_q == LF_REV_ACTIVE &&
     br_q[IDX_Q1] == '0 && br_q[IDX_Q5] == '0 && br_q[IDX_Q6] == '0) |-> out_loop == '0); // R3
endmodule

// File: tb/test_lcs_loop_combiner.sv
module test_lcs_loop_combiner;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid;
  logic               in_ready;
  logic signed [15:0] in_q1, in_q2, in_q5, in_q6;
  logic [2:0]         in_lf_state;
  logic [15:0]        in_cm, in_cm_thr;
  logic               out_valid;
  logic               out_ready;
  logic signed [15:0] out_loop;
  logic               out_cm_high;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcs_loop_combiner i_lcs_loop_combiner (
    .clk, .rst, .in_valid, .in_ready, .in_q1, .in_q2, .in_q5, .in_q6,
    .in_lf_state, .in_cm, .in_cm_thr, .out_valid, .out_ready, .out_loop, .out_cm_high
  );

  function automatic int model(input int q1, input int q2, input int q5, input int q6,
                               input int lf, input bit hi);
    int a, b, s;
    a = (hi && (lf == 1 || lf == 3)) ? 0 : q1;
    b = (hi && (lf == 5 || lf == 7)) ? 0 : q2;
    s = a - q6 + q5 - b;
    if (!(lf == 3 || lf == 7)) s = s >>> 1;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int q1, input int q2, input int q5, input int q6,
                       input int lf, input int cm, input int thr);
    in_q1 = 16'(q1); in_q2 = 16'(q2); in_q5 = 16'(q5); in_q6 = 16'(q6);
    in_lf_state = 3'(lf); in_cm = 16'(cm); in_cm_thr = 16'(thr);
  endtask

  // One sample through the block with the output ready; checks result
  task automatic run_one(input string req, input int q1, input int q2, input int q5,
                         input int q6, input int lf, input int cm, input int thr);
    bit hi;
    hi = (cm > thr);
    @(negedge clk);
    drive(q1, q2, q5, q6, lf, cm, thr);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " flag"}, int'(out_cm_high), int'(hi));
    check({req, " loop"}, int'(out_loop), model(q1, q2, q5, q6, lf, hi));
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 valid", int'(out_valid), 0);
    check("R10 loop", int'(out_loop), 0);
    check("R10 flag", int'(out_cm_high), 0);
    check("R8 ready", int'(in_ready), 1);
  endtask

  task automatic t_flag_threshold;
    run_one("R1 equal", 100, 40, 20, 10, 1, 500, 500);
    run_one("R1 above", 100, 40, 20, 10, 1, 501, 500);
    run_one("R1 below", 100, 40, 20, 10, 1, 3, 500);
  endtask

  task automatic t_q1_forcing;
    run_one("R2 fwd", 1000, 200, 300, 50, 1, 900, 10);
    run_one("R2 tip", 1000, 200, 300, 50, 3, 900, 10);
  endtask

  task automatic t_q2_forcing;
    run_one("R3 rev", 1000, 200, 300, 50, 5, 900, 10);
    run_one("R3 ring", 1000, 200, 300, 50, 7, 900, 10);
  endtask

  task automatic t_open_full;
    run_one("R4 tip", 1234, -100, 55, 7, 3, 0, 10);
    run_one("R4 ring", -500, 300, 20, 40, 7, 0, 10);
  endtask

  task automatic t_halving;
    run_one("R5 odd neg", 0, 3, 0, 0, 0, 0, 10);
    run_one("R5 odd pos", 7, 0, 0, 0, 2, 0, 10);
    run_one("R5 mixed", -801, 17, 44, -9, 6, 0, 10);
  endtask

  task automatic t_no_forcing;
    for (int lf = 0; lf < 8; lf += 2)
      run_one("R6 flag other state", 800, 300, 60, 20, lf, 900, 10);
    run_one("R6 fwd flag clear", 800, 300, 60, 20, 1, 0, 10);
    run_one("R6 ring flag clear", 800, 300, 60, 20, 7, 0, 10);
  endtask

  task automatic t_saturate;
    run_one("R7 pos", 30000, -30000, 30000, -30000, 3, 0, 10);
    run_one("R7 neg", -30000, 30000, -30000, 30000, 7, 0, 10);
    run_one("R7 halved edge", 32767, -32768, 32767, -32768, 0, 0, 10);
  endtask

  task automatic t_backpressure;
    int exp_a;
    exp_a = model(500, 100, 40, 20, 0, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    drive(500, 100, 40, 20, 0, 0, 10);
    in_valid = 1'b1;
    @(negedge clk);
    drive(-900, 0, 0, 0, 3, 999, 1);
    @(negedge clk);
    check("R9 ready low", int'(in_ready), 0);
    check("R9 valid held", int'(out_valid), 1);
    check("R9 loop held", int'(out_loop), exp_a);
    check("R9 flag held", int'(out_cm_high), 0);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 drained", int'(out_valid), 0);
    run_one("R8 after stall", -900, 0, 0, 0, 3, 999, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_flag_threshold();
    t_q1_forcing();
    t_q2_forcing();
    t_open_full();
    t_halving();
    t_no_forcing();
    t_saturate();
    t_backpressure();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 late valid", int'(out_valid), 0);
    check("R10 late flag", int'(out_cm_high), 0);
    finish_run();
  end
endmodule